// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block places START, repeated START and STOP conditions on an open-drain I2C bus. It drives the bus through two active-low pull enables. A value of 0 pulls the line low. A value of 1 releases it, and a released line reads high unless some other device holds it. The host controls the block with a master-enable level and two one-cycle set strobes. Each strobe arms a pending request bit. The block clears that bit when the matching condition has completed on the bus, and it raises a one-cycle `done` pulse at the same time. A programmable divider sets the length of every condition phase.

Independently of its own requests, the block samples both bus lines through a two-flop synchronizer and detects START and STOP conditions made by any master. From those detections it keeps a bus-busy flag. A start request does one of three things. When the block already holds the bus after its own START, the request becomes a repeated START. When the bus is idle, it becomes a plain START. When another master holds the bus, it waits until the bus is free. Every phase in which the block has released SCL is held back while SCL still reads low, so a slave that stretches the clock pauses the sequence.

Top module: `i2c_cond_seq`

## Requirements
- R1: A START pulls SDA low while SCL is released and reads high. SCL is pulled low exactly `div_half`+1 clock cycles after SDA falls.
- R2: A start request is acted on only while `master_en` is 1. With `master_en` at 0 both lines stay released and `start_pend` stays 1. Setting `master_en` later carries out the request.
- R3: While SCL is released, the block changes its SDA drive only to make a START (a falling edge with a start pending) or a STOP (a rising edge with a stop pending). During a repeated START, SDA is released while SCL is still held low.
- R4: `busy` goes to 1 after a START is seen on the synchronized bus lines, from any master, and goes to 0 after a STOP is seen. It is 0 from reset until the first START.
- R5: If a start request arrives while the block is idle and `busy` is 1, the block drives nothing until a STOP frees the bus. It then makes the START.
- R6: If a start request arrives while the block holds the bus (SCL and SDA pulled low after its own START), it makes a repeated START. The order is: release SDA; `div_half`+1 cycles later release SCL; pull SDA low `div_half`+3 cycles after SCL is released (two synchronizer cycles plus one phase); pull SCL low `div_half`+1 cycles after that. `busy` stays 1 throughout.
- R7: A STOP is made only from the held-bus state. SCL is released first, and SDA is released `div_half`+3 cycles later. A stop request made while the block is idle leaves both lines released, raises no `done`, and stays pending.
- R8: While SCL is released but reads low, the current phase does not advance. The phase length counts from the cycle in which the synchronized SCL first reads high.
- R9: `start_pend` and `stop_pend` are set by one-cycle strobes on `set_start` and `set_stop`. Each clears when its condition completes, and `done` is high for exactly one cycle at that moment. A START completes when SCL is pulled low. A STOP completes `div_half`+1 cycles after SDA is released.
- R10: After reset, both drive outputs are 1, and `busy`, `start_pend`, `stop_pend` and `done` are 0.
- R11: When start and stop requests are both pending while the block holds the bus, the STOP is made first. The START is then made once the bus is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_half | input | DIV_W | Phase length minus one, in clock cycles |
| master_en | input | 1 | Master mode enable; start requests wait while 0 |
| set_start | input | 1 | One-cycle strobe that arms a start request |
| set_stop | input | 1 | One-cycle strobe that arms a stop request |
| scl_in | input | 1 | SCL as read from the bus |
| sda_in | input | 1 | SDA as read from the bus |
| scl_drv_n | output | 1 | SCL pull enable, 0 pulls the line low |
| sda_drv_n | output | 1 | SDA pull enable, 0 pulls the line low |
| start_pend | output | 1 | Start request pending |
| stop_pend | output | 1 | Stop request pending |
| busy | output | 1 | Bus busy as seen on the lines |
| done | output | 1 | One-cycle pulse when a requested condition completes |

## Verification
The START, repeated START and STOP sequences are each run with several divider values, including zero. This separates phases that are timed only by the divider from phases that also include the two synchronizer cycles. Separate runs place an external START and STOP on the bus, hold SCL low during the STOP clock phase, and raise both requests together. These runs tell the bus-watched busy flag apart from the block's own requests, and they show that stretching pauses the sequence rather than shortening it. Requests made with master mode off, and a stop request made with the bus idle, show at the pins that nothing is driven and that the request stays pending.

// File: rtl/i2c_cseq_pkg.sv
package i2c_cseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PREP   = 3'd1,
    ST_HOLD   = 3'd2,
    ST_OWN    = 3'd3,
    ST_RS_SDA = 3'd4,
    ST_P_LOW  = 3'd5,
    ST_P_CLK  = 3'd6,
    ST_P_REL  = 3'd7
  } cseq_state_e;

  // SCL is pulled low while the block owns the clock
  function automatic logic scl_pull(input cseq_state_e s);
    return (s == ST_OWN) || (s == ST_RS_SDA) || (s == ST_P_LOW);
  endfunction

  // SDA is pulled low from the START edge until the STOP edge
  function automatic logic sda_pull(input cseq_state_e s);
    return (s == ST_HOLD) || (s == ST_OWN) || (s == ST_P_LOW) || (s == ST_P_CLK);
  endfunction

  function automatic logic timed_phase(input cseq_state_e s);
    return (s != ST_IDLE) && (s != ST_OWN);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_prev;
  logic              sda_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
          end else begin
            scl_ff[0] <= scl_in;
            sda_ff[0] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[g] <= 1'b1;
            sda_ff[g] <= 1'b1;
          end else begin
            scl_ff[g] <= scl_ff[g-1];
            sda_ff[g] <= sda_ff[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  // data edge while the clock stays high in both samples
  assign start_det = scl_s & scl_prev &  sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev &  sda_s;

endmodule

// File: rtl/i2c_busy_track.sv
module i2c_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  output logic busy
);

  logic busy_q;
  logic busy_d;

  always_comb begin
    busy_d = busy_q;
    if (start_det) busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;

  assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);

endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_limit;

  assign at_limit = (cnt_q == limit);
  assign expired  = run & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (run && !at_limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_timer_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  assert_timer_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic start_pend,
  input  logic stop_pend,
  input  logic busy,
  input  logic scl_s,
  input  logic tmr_exp,
  output logic tmr_clr,
  output logic tmr_run,
  output logic fin_start,
  output logic fin_stop,
  output logic scl_drv_n,
  output logic sda_drv_n
);

  cseq_state_e state_q;
  cseq_state_e state_d;
  logic        scl_rel_q;
  logic        sda_rel_q;

  always_comb begin
    state_d   = state_q;
    fin_start = 1'b0;
    fin_stop  = 1'b0;
    case (state_q)
      ST_IDLE:   if (start_pend && master_en && !busy) state_d = ST_PREP;
      ST_PREP:   if (tmr_exp) state_d = ST_HOLD;
      ST_HOLD:   if (tmr_exp) begin
                   state_d   = ST_OWN;
                   fin_start = 1'b1;
                 end
      ST_OWN:    if (stop_pend) state_d = ST_P_LOW;
                 else if (start_pend && master_en) state_d = ST_RS_SDA;
      ST_RS_SDA: if (tmr_exp) state_d = ST_PREP;
      ST_P_LOW:  if (tmr_exp) state_d = ST_P_CLK;
      ST_P_CLK:  if (tmr_exp) state_d = ST_P_REL;
      ST_P_REL:  if (tmr_exp) begin
                   state_d  = ST_IDLE;
                   fin_stop = 1'b1;
                 end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      scl_rel_q <= 1'b1;
      sda_rel_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      scl_rel_q <= ~scl_pull(state_d);
      sda_rel_q <= ~sda_pull(state_d);
    end
  end

  // a released clock only counts once the bus reads it high
  assign tmr_run   = timed_phase(state_q) && (scl_rel_q ? scl_s : 1'b1);
  assign tmr_clr   = (state_d != state_q);
  assign scl_drv_n = scl_rel_q;
  assign sda_drv_n = sda_rel_q;

  assert_sda_moves_low_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drv_n && $past(scl_drv_n) && (sda_drv_n != $past(sda_drv_n)))
      |-> (($fell(sda_drv_n) && start_pend) || ($rose(sda_drv_n) && stop_pend)));
  assert_idle_needs_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !master_en) |=> (state_q == ST_IDLE));
  assert_stretch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drv_n && state_q != ST_IDLE && !scl_s) |=> $stable(state_q));
  assert_idle_waits_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && busy) |=> (scl_drv_n && sda_drv_n));

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int DIV_W     = 8,
  parameter int SYNC_FLOP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             master_en,
  input  logic             set_start,
  input  logic             set_stop,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drv_n,
  output logic             sda_drv_n,
  output logic             start_pend,
  output logic             stop_pend,
  output logic             busy,
  output logic             done
);

  logic scl_s, sda_s, start_det, stop_det;
  logic tmr_clr, tmr_run, tmr_exp;
  logic fin_start, fin_stop;
  logic start_q, start_d, stop_q, stop_d, done_q;

  i2c_line_sync #(.STAGES(SYNC_FLOP)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .busy(busy)
  );

  i2c_half_timer #(.W(DIV_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .limit(div_half), .expired(tmr_exp)
  );

  i2c_cond_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .start_pend(start_q), .stop_pend(stop_q), .busy(busy),
    .scl_s(scl_s), .tmr_exp(tmr_exp), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .fin_start(fin_start), .fin_stop(fin_stop),
    .scl_drv_n(scl_drv_n), .sda_drv_n(sda_drv_n)
  );

  always_comb begin
    start_d = start_q;
    stop_d  = stop_q;
    if (set_start)      start_d = 1'b1;
    else if (fin_start) start_d = 1'b0;
    if (set_stop)       stop_d  = 1'b1;
    else if (fin_stop)  stop_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
      done_q  <= fin_start | fin_stop;
    end
  end

  assign start_pend = start_q;
  assign stop_pend  = stop_q;
  assign done       = done_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_clear_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pend) |-> done);
  assert_stop_clear_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_pend) |-> done);
  assert_start_edge_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_drv_n) && scl_drv_n) |-> $past(master_en));

endmodule

// File: tb/i2c_cond_seq_test.sv
`timescale 1ns/1ps
module i2c_cond_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_half = 8'd2;
  logic       master_en = 1'b0;
  logic       set_start = 1'b0;
  logic       set_stop = 1'b0;
  logic       ext_scl = 1'b1;
  logic       ext_sda = 1'b1;
  logic       scl_drv_n, sda_drv_n, start_pend, stop_pend, busy, done;
  logic       scl_in, sda_in;

  assign scl_in = scl_drv_n & ext_scl;
  assign sda_in = sda_drv_n & ext_sda;

  always #10 clk = ~clk;

  i2c_cond_seq uut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .master_en(master_en),
    .set_start(set_start), .set_stop(set_stop), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drv_n(scl_drv_n), .sda_drv_n(sda_drv_n), .start_pend(start_pend),
    .stop_pend(stop_pend), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int done_cnt = 0;
  int t_scl_rise = 0, t_scl_fall = 0, t_sda_rise = 0, t_sda_fall = 0;
  logic pscl = 1'b1, psda = 1'b1;

  // divider, START hold gap (R1/R6), released-clock gap (R6/R7)
  localparam int VEC [0:3][0:2] = '{'{0, 1, 3}, '{1, 2, 4}, '{3, 4, 6}, '{6, 7, 9}};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (scl_drv_n === 1'b1 && pscl === 1'b0) t_scl_rise = cyc;
    if (scl_drv_n === 1'b0 && pscl === 1'b1) t_scl_fall = cyc;
    if (sda_drv_n === 1'b1 && psda === 1'b0) t_sda_rise = cyc;
    if (sda_drv_n === 1'b0 && psda === 1'b1) t_sda_fall = cyc;
    pscl = scl_drv_n;
    psda = sda_drv_n;
    if (done === 1'b1) done_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    set_start = 1'b1; step(1); set_start = 1'b0;
  endtask

  task automatic pulse_stop();
    set_stop = 1'b1; step(1); set_stop = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    int k = 0;
    while (done_cnt < target && k < 3000) begin step(1); k++; end
    chk(req, done_cnt, target);
  endtask

  function automatic string pfx(input string r, input int d);
    return $sformatf("%s div=%0d", r, d);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R10 reset state
    chk("R10 scl_drv_n", scl_drv_n, 1);
    chk("R10 sda_drv_n", sda_drv_n, 1);
    chk("R10 busy", busy, 0);
    chk("R10 pend", {start_pend, stop_pend}, 0);
    chk("R10 done", done_cnt, 0);

    // R2: request held off without master mode
    pulse_start();
    step(30);
    chk("R2 lines released", {scl_drv_n, sda_drv_n}, 3);
    chk("R2 start_pend kept", start_pend, 1);
    chk("R2 no done", done_cnt, 0);
    master_en = 1'b1;
    wait_done(1, "R2 start after enable");
    chk("R2 scl held low", scl_drv_n, 0);
    pulse_stop();
    wait_done(2, "R7 stop");
    step(5);
    chk("R4 busy clear after stop", busy, 0);

    // table walk: start, repeated start, stop per divider
    for (int v = 0; v < 4; v++) begin
      div_half = 8'(VEC[v][0]);
      step(2);
      pulse_start();
      wait_done(done_cnt + 1, pfx("R1 start done", VEC[v][0]));
      chk(pfx("R1 sda->scl gap", VEC[v][0]), t_scl_fall - t_sda_fall, VEC[v][1]);
      chk(pfx("R9 start_pend cleared", VEC[v][0]), start_pend, 0);
      step(4);
      chk(pfx("R4 busy set", VEC[v][0]), busy, 1);
      pulse_start();
      wait_done(done_cnt + 1, pfx("R6 rstart done", VEC[v][0]));
      chk(pfx("R6 sda rel->scl rel", VEC[v][0]), t_scl_rise - t_sda_rise, VEC[v][1]);
      chk(pfx("R6 scl rel->sda low", VEC[v][0]), t_sda_fall - t_scl_rise, VEC[v][2]);
      chk(pfx("R1 rstart sda->scl", VEC[v][0]), t_scl_fall - t_sda_fall, VEC[v][1]);
      chk(pfx("R3 sda rose before scl", VEC[v][0]), int'(t_sda_rise < t_scl_rise), 1);
      chk(pfx("R6 busy kept", VEC[v][0]), busy, 1);
      pulse_stop();
      wait_done(done_cnt + 1, pfx("R7 stop done", VEC[v][0]));
      chk(pfx("R7 scl rel->sda rel", VEC[v][0]), t_sda_rise - t_scl_rise, VEC[v][2]);
      chk(pfx("R9 stop_pend cleared", VEC[v][0]), stop_pend, 0);
      step(4);
      chk(pfx("R4 busy cleared", VEC[v][0]), busy, 0);
    end

    // R7: stop while idle has no effect and stays pending
    div_half = 8'd2;
    begin
      int base;
      base = done_cnt;
      pulse_stop();
      step(30);
      chk("R7 idle stop lines", {scl_drv_n, sda_drv_n}, 3);
      chk("R7 idle stop no done", done_cnt, base);
      chk("R7 idle stop pending", stop_pend, 1);
      pulse_start();
      wait_done(base + 2, "R7 pending stop after start");
      step(5);
      chk("R7 released after pair", {scl_drv_n, sda_drv_n}, 3);
      chk("R9 both pend clear", {start_pend, stop_pend}, 0);
      chk("R4 busy after pair", busy, 0);
    end

    // R5: another master holds the bus
    begin
      int base;
      base = done_cnt;
      ext_sda = 1'b0;
      step(5);
      chk("R4 busy from external start", busy, 1);
      pulse_start();
      step(30);
      chk("R5 waits while busy", {scl_drv_n, sda_drv_n}, 3);
      chk("R5 no done while busy", done_cnt, base);
      ext_sda = 1'b1;
      wait_done(base + 1, "R5 start after free");
      chk("R5 owns bus", {scl_drv_n, sda_drv_n}, 0);
    end

    // R8: slave stretches SCL during the STOP clock phase
    begin
      int rel;
      int k = 0;
      ext_scl = 1'b0;
      pulse_stop();
      while (scl_drv_n !== 1'b1 && k < 200) begin step(1); k++; end
      step(10);
      chk("R8 sda held during stretch", sda_drv_n, 0);
      chk("R8 stop still pending", stop_pend, 1);
      ext_scl = 1'b1;
      rel = cyc;
      wait_done(done_cnt + 1, "R8 stop after stretch");
      chk("R8 release->sda gap", t_sda_rise - rel, 5);
    end

    // R11: both requests while owning the bus
    step(5);
    pulse_start();
    wait_done(done_cnt + 1, "R11 own bus");
    set_start = 1'b1; set_stop = 1'b1;
    step(1);
    set_start = 1'b0; set_stop = 1'b0;
    wait_done(done_cnt + 1, "R11 first done");
    chk("R11 stop first", {start_pend, stop_pend}, 2'b10);
    chk("R11 released after stop", sda_drv_n, 1);
    wait_done(done_cnt + 1, "R11 second done");
    chk("R11 start second", {scl_drv_n, sda_drv_n, start_pend}, 0);
    pulse_stop();
    wait_done(done_cnt + 1, "R11 final stop");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule